// File: doc/BRIEF.md
# Prescaled Free-Running Timer Counter

A 16-bit up-counter that advances once every four bus clocks. It is read as two bytes through a byte-wide register port. The count cannot be written. Software sees it at two address pairs, the main view and the alternate view, and both return the same value. Reading a high byte captures the low byte into a snapshot register, so a high-then-low read pair always returns one coherent 16-bit value, even when the count moves between the two accesses.

When the count wraps from 0xFFFF to 0x0000, an overflow flag is set. An interrupt request follows the flag whenever the overflow interrupt is enabled. The flag is cleared in two steps. Software first reads the status register while the flag is set, and then reads the high byte of the main view. The alternate view never disturbs the flag, so a task can sample time through it without losing a pending overflow.

Read data is combinational from the address. Read side effects (snapshot, flag arming and clearing) take effect on the clock edge at which `rd_en_i` is high. Register map on `addr_i`: 0 status (bit 7 = overflow flag), 1 control (bit 0 = overflow interrupt enable, read/write), 2 main high, 3 main low, 4 alternate high, 5 alternate low. Other addresses read 0.

Top module: `frc_timer`

## Requirements
- R1: After reset the count is 0xFFFC, the overflow flag (status bit 7) is 0, the interrupt enable (control bit 0) is 0 and `irq_o` is low.
- R2: The count increases by exactly one every four clock edges. The first increment comes on the fourth edge after reset is released.
- R3: The clock edge on which the count goes from 0xFFFF to 0x0000 sets the overflow flag, which then reads as 0x80 at address 0.
- R4: `irq_o` is high exactly while the overflow flag is 1 and control bit 0 is 1. Control bit 0 is written through address 1.
- R5: A high-byte read at address 2 or 4 captures the current low byte. The next low-byte read, at address 3 or 5, returns that captured value.
- R6: Further high-byte reads before that low-byte read leave the captured value unchanged.
- R7: A low-byte read ends the sequence. A low-byte read with no sequence pending returns the live low byte.
- R8: Reads at addresses 4 and 5 never clear the overflow flag.
- R9: The overflow flag clears on a read at address 2 only when a status read made while the flag was 1 came before it. A read at address 2 without that status read leaves the flag set.
- R10: When a wrap and a clearing read at address 2 fall on the same edge, the flag stays set.
- R11: Writes to addresses 2 to 5 have no effect on the count.
- R12: The main and alternate views return the same count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rd_en_i | input | 1 | Read strobe; side effects on the clock edge |
| wr_en_i | input | 1 | Write strobe |
| addr_i | input | 3 | Register address |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Read data for `addr_i` |
| irq_o | output | 1 | Overflow interrupt request |

## Verification
The assertions assume a single register access per cycle, with `addr_i` stable while `rd_en_i` is high, and that software never writes the count. Under those assumptions every change of the count is a single step and every fall of the flag can be traced to a main high-byte read. The stimulus issues at most one access per cycle, changing the strobe and address only on falling edges. It mixes random reads and writes over the whole map, including writes aimed at the count bytes, with directed reads placed on exact edge counts around the wrap. A second instance with a halved prescale is used to reach a second wrap within the run time.

// File: rtl/frc_pkg.sv
package frc_pkg;
  localparam int unsigned CNT_W = 16;
  localparam logic [2:0] A_STAT    = 3'd0;
  localparam logic [2:0] A_CTRL    = 3'd1;
  localparam logic [2:0] A_MAIN_HI = 3'd2;
  localparam logic [2:0] A_MAIN_LO = 3'd3;
  localparam logic [2:0] A_ALT_HI  = 3'd4;
  localparam logic [2:0] A_ALT_LO  = 3'd5;
  localparam int unsigned FLAG_BIT = 7;
endpackage

// File: rtl/frc_prescaler.sv
module frc_prescaler #(
  parameter int unsigned DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned PW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          ph_q <= '0;
    else if (ph_q == LAST) ph_q <= '0;
    else                  ph_q <= ph_q + 1'b1;
  end

  assign tick_o = (ph_q == LAST);
endmodule

// File: rtl/frc_counter.sv
module frc_counter #(
  parameter int unsigned W = 16,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= RST_VAL;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = tick_i && (&cnt_q);
endmodule

// File: rtl/frc_snap.sv
module frc_snap #(
  parameter int unsigned BW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hi_rd_i,
  input  logic          lo_rd_i,
  input  logic [BW-1:0] live_i,
  output logic [BW-1:0] lo_o,
  output logic          held_o,
  output logic [BW-1:0] snap_o
);
  logic          held_q;
  logic [BW-1:0] snap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_q <= 1'b0;
      snap_q <= '0;
    end else if (hi_rd_i && !held_q) begin
      held_q <= 1'b1;
      snap_q <= live_i;
    end else if (lo_rd_i) begin
      held_q <= 1'b0;
    end
  end

  assign lo_o   = held_q ? snap_q : live_i;
  assign held_o = held_q;
  assign snap_o = snap_q;
endmodule

// File: rtl/frc_ovf_flag.sv
module frc_ovf_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic stat_rd_i,
  input  logic clr_rd_i,
  output logic flag_o
);
  logic flag_q, armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else if (set_i) begin
      flag_q <= 1'b1;  // set beats a same-cycle clear
    end else if (clr_rd_i && armed_q) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else if (stat_rd_i && flag_q) begin
      armed_q <= 1'b1;
    end else if (!flag_q) begin
      armed_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/frc_timer.sv
module frc_timer
  import frc_pkg::*;
#(
  parameter int unsigned      PRESCALE_DIV = 4,
  parameter logic [CNT_W-1:0] RESET_COUNT  = 16'hFFFC
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rd_en_i,
  input  logic       wr_en_i,
  input  logic [2:0] addr_i,
  input  logic [7:0] wr_data_i,
  output logic [7:0] rd_data_o,
  output logic       irq_o
);
  localparam int unsigned BW = CNT_W / 2;

  logic             tick, wrap, held, tof, toie_q;
  logic [CNT_W-1:0] cnt_q;
  logic [BW-1:0]    lo_byte, snap;
  logic             rd_stat, rd_hi, rd_lo, rd_main_hi;
  logic             unused_wr;

  assign unused_wr  = ^wr_data_i[7:1];
  assign rd_stat    = rd_en_i && (addr_i == A_STAT);
  assign rd_main_hi = rd_en_i && (addr_i == A_MAIN_HI);
  assign rd_hi      = rd_en_i && (addr_i == A_MAIN_HI || addr_i == A_ALT_HI);
  assign rd_lo      = rd_en_i && (addr_i == A_MAIN_LO || addr_i == A_ALT_LO);

  frc_prescaler #(.DIV(PRESCALE_DIV)) u_pre (
    .clk_i, .rst_ni, .tick_o(tick)
  );

  frc_counter #(.W(CNT_W), .RST_VAL(RESET_COUNT)) u_cnt (
    .clk_i, .rst_ni, .tick_i(tick), .cnt_o(cnt_q), .wrap_o(wrap)
  );

  frc_snap #(.BW(BW)) u_snap (
    .clk_i, .rst_ni, .hi_rd_i(rd_hi), .lo_rd_i(rd_lo),
    .live_i(cnt_q[BW-1:0]), .lo_o(lo_byte), .held_o(held), .snap_o(snap)
  );

  frc_ovf_flag u_flag (
    .clk_i, .rst_ni, .set_i(wrap), .stat_rd_i(rd_stat),
    .clr_rd_i(rd_main_hi), .flag_o(tof)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            toie_q <= 1'b0;
    else if (wr_en_i && addr_i == A_CTRL)   toie_q <= wr_data_i[0];
  end

  always_comb begin
    unique case (addr_i)
      A_STAT:              rd_data_o = 8'(tof) << FLAG_BIT;
      A_CTRL:              rd_data_o = {7'd0, toie_q};
      A_MAIN_HI, A_ALT_HI: rd_data_o = cnt_q[CNT_W-1:BW];
      A_MAIN_LO, A_ALT_LO: rd_data_o = lo_byte;
      default:             rd_data_o = 8'd0;
    endcase
  end

  assign irq_o = tof && toie_q;
endmodule

// File: rtl/frc_timer_chk.sv
module frc_timer_chk
  import frc_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rd_en_i,
  input logic [2:0]       addr_i,
  input logic             irq_o,
  input logic [CNT_W-1:0] cnt,
  input logic             tof,
  input logic             held,
  input logic [7:0]       snap
);
  p_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cnt) |-> cnt == $past(cnt) + 16'd1);

  p_wrap_sets_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt == 16'h0000 && $past(cnt) == 16'hFFFF) |-> tof);

  p_irq_needs_flag_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> tof);

  p_snap_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && (addr_i == A_MAIN_HI || addr_i == A_ALT_HI) && held) |=> $stable(snap));

  p_alt_keeps_flag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && (addr_i == A_ALT_HI || addr_i == A_ALT_LO) && tof) |=> tof);

  p_clear_source_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tof) |-> $past(rd_en_i && addr_i == A_MAIN_HI));
endmodule

bind frc_timer frc_timer_chk u_chk (
  .clk_i, .rst_ni, .rd_en_i, .addr_i, .irq_o,
  .cnt(cnt_q), .tof(tof), .held(held), .snap(snap)
);

// File: tb/frc_timer_test.sv
module frc_timer_test;
  import frc_pkg::*;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rd_en = 1'b0, wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdat = '0;
  logic [7:0] rdat;
  logic       irq;
  logic       f_rd_en = 1'b0;
  logic [2:0] f_addr = '0;
  logic [7:0] f_rdat;
  logic       f_irq;
  int         n = 0;
  int         errors = 0, checks = 0;

  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) n <= 0;
    else        n <= n + 1;
  end

  frc_timer uut (
    .clk_i(clk), .rst_ni(rst_n), .rd_en_i(rd_en), .wr_en_i(wr_en),
    .addr_i(addr), .wr_data_i(wdat), .rd_data_o(rdat), .irq_o(irq)
  );

  frc_timer #(.PRESCALE_DIV(2)) uut_fast (
    .clk_i(clk), .rst_ni(rst_n), .rd_en_i(f_rd_en), .wr_en_i(1'b0),
    .addr_i(f_addr), .wr_data_i(8'd0), .rd_data_o(f_rdat), .irq_o(f_irq)
  );

  function automatic logic [15:0] exp_cnt(int edges);
    return 16'(32'hFFFC + edges / 4);
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h (edge %0d)", req, act, exp, n);
    end
  endtask

  task automatic finish_up();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; rd_en = 0; wr_en = 0; f_rd_en = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_n(int k);
    while (n < k) @(negedge clk);
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    rd_en = 1'b1; addr = a;
    #1 d = rdat;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] v);
    wr_en = 1'b1; addr = a; wdat = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_up();
  end

  initial begin
    logic [7:0] d, keep;
    logic [15:0] e;
    logic m_held, m_tof, m_armed, m_toie;
    logic [7:0] m_buf;
    void'($urandom(32'd4242));

    // run 1: reset state, stepping, snapshot, wrap, irq
    do_reset();
    chk("R1 irq", 16'(irq), 0);
    rd(A_STAT, d);    chk("R1 status", 16'(d), 16'h00);
    rd(A_CTRL, d);    chk("R1 ctrl", 16'(d), 16'h00);
    wait_n(2);
    rd(A_MAIN_HI, d); chk("R1 count hi", 16'(d), 16'hFF);
    wait_n(5);
    rd(A_MAIN_LO, d); chk("R5 buffered lo", 16'(d), 16'hFC);
    wait_n(6);
    rd(A_MAIN_LO, d); chk("R7 live lo", 16'(d), 16'(exp_cnt(6) & 8'hFF));
    wait_n(3);
    rd(A_ALT_LO, d);  // placeholder no-op when already past
    wait_n(8);
    rd(A_ALT_LO, d);  chk("R2 lo after 8 edges", 16'(d), 16'hFE);
    rd(A_ALT_LO, d);  chk("R2 lo after 9 edges", 16'(d), 16'hFE);
    wait_n(14);
    rd(A_STAT, d);    chk("R3 no flag before wrap", 16'(d), 16'h00);
    wait_n(16);
    rd(A_STAT, d);    chk("R3 flag after wrap", 16'(d), 16'h80);
    chk("R4 irq masked", 16'(irq), 0);
    wr(A_CTRL, 8'h01);
    #1 chk("R4 irq enabled", 16'(irq), 1);
    wr(A_CTRL, 8'h00);
    #1 chk("R4 irq disabled", 16'(irq), 0);

    // R6: repeated high reads keep first snapshot
    wait_n(24);
    e = exp_cnt(n); keep = e[7:0];
    rd(A_ALT_HI, d);  chk("R12 alt hi", 16'(d), 16'(e[15:8]));
    wait_n(40);
    rd(A_MAIN_HI, d);
    rd(A_ALT_HI, d);
    e = exp_cnt(n);
    rd(A_MAIN_LO, d); chk("R6 snapshot kept", 16'(d), 16'(keep));
    chk("R6 live moved", 16'(e[7:0] != keep), 1);

    // R11: writes to count bytes ignored
    for (int i = 2; i <= 5; i++) wr(3'(i), 8'h5A);
    e = exp_cnt(n);
    rd(A_ALT_LO, d);  chk("R11 lo after writes", 16'(d), 16'(e[7:0]));
    e = exp_cnt(n);
    rd(A_ALT_HI, d);  chk("R11 hi after writes", 16'(d), 16'(e[15:8]));
    rd(A_ALT_LO, d);

    // run 2: flag clearing rules
    do_reset();
    wait_n(20);
    rd(A_MAIN_HI, d); rd(A_MAIN_LO, d);
    rd(A_STAT, d);    chk("R9 unarmed read keeps flag", 16'(d), 16'h80);
    rd(A_ALT_HI, d);  rd(A_ALT_LO, d);
    rd(A_STAT, d);    chk("R8 alt reads keep flag", 16'(d), 16'h80);
    rd(A_MAIN_HI, d); rd(A_MAIN_LO, d);
    rd(A_STAT, d);    chk("R9 armed read clears flag", 16'(d), 16'h00);

    // random mix against a bench model
    m_held = 0; m_tof = 0; m_armed = 0; m_toie = 0; m_buf = '0;
    for (int k = 0; k < 400; k++) begin
      int op;
      op = int'($urandom % 9);
      e = exp_cnt(n);
      chk("R4 irq model", 16'(irq), 16'(m_tof && m_toie));
      case (op)
        0: begin
          rd(A_STAT, d); chk("R3 status model", 16'(d), 16'({m_tof, 7'd0}));
          if (m_tof) m_armed = 1;
        end
        1: begin
          logic b;
          b = 1'($urandom);
          wr(A_CTRL, {7'($urandom), b}); m_toie = b;
        end
        2, 4: begin
          rd(op == 2 ? A_MAIN_HI : A_ALT_HI, d);
          chk("R12 hi view model", 16'(d), 16'(e[15:8]));
          if (!m_held) begin m_held = 1; m_buf = e[7:0]; end
          if (op == 2 && m_armed && m_tof) begin m_tof = 0; m_armed = 0; end
        end
        3, 5: begin
          rd(op == 3 ? A_MAIN_LO : A_ALT_LO, d);
          chk("R5 lo view model", 16'(d), 16'(m_held ? m_buf : e[7:0]));
          m_held = 0;
        end
        6: wr(3'(2 + $urandom % 4), 8'($urandom));
        7: begin rd(A_CTRL, d); chk("R4 ctrl model", 16'(d), 16'(m_toie)); end
        default: @(negedge clk);
      endcase
    end

    // run 3: wrap and clear on the same edge (fast instance)
    do_reset();
    wait_n(9);
    f_rd_en = 1'b1; f_addr = A_STAT;
    #1 chk("R3 fast flag", 16'(f_rdat), 16'h80);
    @(negedge clk); f_rd_en = 1'b0;
    wait_n(131079);
    f_rd_en = 1'b1; f_addr = A_MAIN_HI;
    #1 chk("R10 count before wrap", 16'(f_rdat), 16'hFF);
    @(negedge clk); f_rd_en = 1'b0; f_addr = A_STAT;
    #1 chk("R10 set wins over clear", 16'(f_rdat), 16'h80);
    f_addr = A_MAIN_LO;
    #1 chk("R10 snapshot low", 16'(f_rdat), 16'hFF);

    finish_up();
  end
endmodule